// File: doc/BRIEF.md
# Break Execute Unit

This block is the execute stage for the two break instructions of a 32-bit soft processor, the register-target form and the immediate-target form. It also serves an external hardware-break request. Every cycle it takes the instruction word, the current PC, the value of the rb operand, any pending high-half immediate prefix, the current machine status register and the base-vector address. One clock later it presents a registered result: a PC redirect, a write-back to the register file, a new status word, a strobe that clears the load-reserve reservation, and a privileged-instruction trap pulse.

The register form jumps to the address in rb. The immediate form jumps to its immediate, which is taken as an absolute address. Both forms can store a return link. The side effects on the status word depend on the immediate vector: the debug offset does not set the break-in-progress flag, and the syscall and debug offsets save the user and virtual mode flags into their shadow bits. A hardware break overrides any instruction presented in the same cycle. It is refused while an immediate prefix or a delay slot is still pending, and in that case the instruction executes as usual.

Top module: `brk_exec_unit`

## Requirements
- R1: The register form is decoded only when bits 31:26 = 100110, bits 20:16 = 01100 and bits 10:0 = 0. The immediate form is decoded only when bits 31:26 = 101110 and bits 20:16 = 01100. Any other word, or valid_i low, leaves every strobe output low.
- R2: The register form redirects to the rb operand and writes a status word with the break-in-progress bit (bit 3) set. All other status bits carry through unchanged.
- R3: The immediate form redirects to its immediate as an absolute address. Without a prefix the immediate is bits 15:0 sign-extended. With a prefix it is {prefix, bits 15:0}.
- R4: When rd (bits 25:21) is non-zero, either form writes pc_i + 4 to register rd. When rd is zero, no write-back happens.
- R5: Every executed break instruction pulses res_clr_o. A hardware break does not pulse it.
- R6: The immediate form sets break-in-progress for every immediate except 0x18. For 0x18 that bit passes through unchanged.
- R7: For immediate 0x8 or 0x18, the new status has bit 12 = old bit 11 and bit 14 = old bit 13, with bits 11 and 13 cleared.
- R8: In user mode (status bit 11 set), the register form always traps, and the immediate form traps unless its immediate is 0x8 or 0x18. A trap is a one-cycle pulse on trap_o. During it the redirect, write-back, status-write and reservation strobes stay low, and next_pc_o and msr_o keep their prior values.
- R9: An accepted hardware break redirects to base_vec_i + 0x18 and writes pc_i to r16. Its status word sets break-in-progress and saves the mode flags as in R7. It pulses hw_ack_o.
- R10: A hardware break wins over a same-cycle instruction. It is refused while imm_pfx_valid_i or dslot_pend_i is high, and the instruction then executes.
- R11: After reset every output is zero. All results appear exactly one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rb_val_i | input | 32 | Value of the rb operand |
| imm_pfx_valid_i | input | 1 | A high-half immediate prefix is pending |
| imm_pfx_i | input | 16 | Prefix upper half |
| dslot_pend_i | input | 1 | A delay slot is pending |
| msr_i | input | 32 | Current status word |
| base_vec_i | input | 32 | Base address of the vector table |
| hw_brk_i | input | 1 | Hardware-break request |
| redirect_o | output | 1 | Take next_pc_o |
| next_pc_o | output | 32 | Redirect target |
| wb_en_o | output | 1 | Register write-back strobe |
| wb_addr_o | output | 5 | Write-back register index |
| wb_data_o | output | 32 | Write-back value |
| msr_we_o | output | 1 | Status write strobe |
| msr_o | output | 32 | New status word |
| res_clr_o | output | 1 | Set reservation address to all ones |
| trap_o | output | 1 | Privileged-instruction trap pulse |
| hw_ack_o | output | 1 | Hardware break accepted |

## Verification
The bench aims at the vector-dependent status handling. A design that sets break-in-progress for the debug offset, or that skips the mode-flag save for the syscall offset, gives a wrong msr_o. User-mode cases check that only the two permitted vectors pass. A trap that leaks a redirect or overwrites next_pc_o is caught at the held outputs. Prefix widening and sign extension are checked with a negative immediate, and a link to r0 must not raise wb_en_o. Arbitration is checked against a same-cycle break instruction, where a hardware break that loses or that ignores a pending delay slot shows up at once in next_pc_o and hw_ack_o.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned RIDX_W    = 5;
  localparam int unsigned IMM_W     = 16;
  localparam int unsigned OPC_W     = 6;

  localparam logic [OPC_W-1:0]  OPC_BRK_REG = 6'b100110;
  localparam logic [OPC_W-1:0]  OPC_BRK_IMM = 6'b101110;
  localparam logic [RIDX_W-1:0] SUB_BRK     = 5'b01100;

  // status word bit positions
  localparam int unsigned ST_BIP = 3;
  localparam int unsigned ST_UM  = 11;
  localparam int unsigned ST_UMS = 12;
  localparam int unsigned ST_VM  = 13;
  localparam int unsigned ST_VMS = 14;

  localparam logic [XLEN-1:0] VEC_SYSCALL = 32'h0000_0008;
  localparam logic [XLEN-1:0] VEC_DEBUG   = 32'h0000_0018;
  localparam logic [RIDX_W-1:0] HW_LINK_REG = 5'd16;
  localparam logic [XLEN-1:0] INSN_STEP   = 32'd4;

  typedef struct packed {
    logic              is_reg;
    logic              is_imm;
    logic [RIDX_W-1:0] rd;
    logic [XLEN-1:0]   imm;
  } brk_dec_t;
endpackage

// File: rtl/brk_decode.sv
module brk_decode
  import brk_pkg::*;
(
  input  logic [XLEN-1:0]  instr_i,
  input  logic             pfx_valid_i,
  input  logic [IMM_W-1:0] pfx_i,
  output brk_dec_t         dec_o
);
  localparam int unsigned LOW_ZERO_W = 11;

  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] sub;
  logic [IMM_W-1:0]  lo;

  assign opc = instr_i[XLEN-1 -: OPC_W];
  assign sub = instr_i[20:16];
  assign lo  = instr_i[IMM_W-1:0];

  always_comb begin
    dec_o.is_reg = (opc == OPC_BRK_REG) && (sub == SUB_BRK) &&
                   (instr_i[LOW_ZERO_W-1:0] == '0);
    dec_o.is_imm = (opc == OPC_BRK_IMM) && (sub == SUB_BRK);
    dec_o.rd     = instr_i[25:21];
    if (pfx_valid_i) dec_o.imm = {pfx_i, lo};
    else             dec_o.imm = {{(XLEN-IMM_W){lo[IMM_W-1]}}, lo};
  end
endmodule

// File: rtl/brk_msr_upd.sv
module brk_msr_upd
  import brk_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  input  logic            set_bip_i,
  input  logic            save_mode_i,
  output logic [XLEN-1:0] msr_o
);
  always_comb begin
    msr_o = msr_i;
    if (save_mode_i) begin
      msr_o[ST_UMS] = msr_i[ST_UM];
      msr_o[ST_VMS] = msr_i[ST_VM];
      msr_o[ST_UM]  = 1'b0;
      msr_o[ST_VM]  = 1'b0;
    end
    if (set_bip_i) msr_o[ST_BIP] = 1'b1;
  end
endmodule

// File: rtl/brk_exec_unit.sv
module brk_exec_unit
  import brk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [31:0]       pc_i,
  input  logic [31:0]       rb_val_i,
  input  logic              imm_pfx_valid_i,
  input  logic [15:0]       imm_pfx_i,
  input  logic              dslot_pend_i,
  input  logic [31:0]       msr_i,
  input  logic [31:0]       base_vec_i,
  input  logic              hw_brk_i,
  output logic              redirect_o,
  output logic [31:0]       next_pc_o,
  output logic              wb_en_o,
  output logic [4:0]        wb_addr_o,
  output logic [31:0]       wb_data_o,
  output logic              msr_we_o,
  output logic [31:0]       msr_o,
  output logic              res_clr_o,
  output logic              trap_o,
  output logic              hw_ack_o
);
  brk_dec_t dec;
  logic user_mode, vec_sys, hw_take;
  logic reg_go, reg_trap, imm_go, imm_trap, insn_go;
  logic set_bip, save_mode;
  logic [XLEN-1:0] msr_new, tgt, link_val;
  logic [RIDX_W-1:0] link_reg;
  logic link_en;

  brk_decode u_dec (
    .instr_i     (instr_i),
    .pfx_valid_i (imm_pfx_valid_i),
    .pfx_i       (imm_pfx_i),
    .dec_o       (dec)
  );

  assign user_mode = msr_i[ST_UM];
  assign vec_sys   = (dec.imm == VEC_SYSCALL) || (dec.imm == VEC_DEBUG);
  assign hw_take   = hw_brk_i && !imm_pfx_valid_i && !dslot_pend_i;

  assign reg_trap = !hw_take && valid_i && dec.is_reg && user_mode;
  assign reg_go   = !hw_take && valid_i && dec.is_reg && !user_mode;
  assign imm_trap = !hw_take && valid_i && dec.is_imm && user_mode && !vec_sys;
  assign imm_go   = !hw_take && valid_i && dec.is_imm && !(user_mode && !vec_sys);
  assign insn_go  = reg_go || imm_go;

  always_comb begin
    set_bip   = 1'b0;
    save_mode = 1'b0;
    tgt       = '0;
    link_reg  = dec.rd;
    link_val  = pc_i + INSN_STEP;
    link_en   = 1'b0;
    if (hw_take) begin
      set_bip   = 1'b1;
      save_mode = 1'b1;
      tgt       = base_vec_i + VEC_DEBUG;
      link_reg  = HW_LINK_REG;
      link_val  = pc_i;
      link_en   = 1'b1;
    end else if (reg_go) begin
      set_bip = 1'b1;
      tgt     = rb_val_i;
      link_en = (dec.rd != '0);
    end else if (imm_go) begin
      set_bip   = (dec.imm != VEC_DEBUG);
      save_mode = vec_sys;
      tgt       = dec.imm;
      link_en   = (dec.rd != '0);
    end
  end

  brk_msr_upd u_msr (
    .msr_i       (msr_i),
    .set_bip_i   (set_bip),
    .save_mode_i (save_mode),
    .msr_o       (msr_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      wb_en_o    <= 1'b0;
      msr_we_o   <= 1'b0;
      res_clr_o  <= 1'b0;
      trap_o     <= 1'b0;
      hw_ack_o   <= 1'b0;
    end else begin
      redirect_o <= hw_take || insn_go;
      wb_en_o    <= link_en;
      msr_we_o   <= hw_take || insn_go;
      res_clr_o  <= insn_go;
      trap_o     <= reg_trap || imm_trap;
      hw_ack_o   <= hw_take;
    end
  end

  // data outputs hold unless an accepted operation updates them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      msr_o     <= '0;
    end else if (hw_take || insn_go) begin
      next_pc_o <= tgt;
      msr_o     <= msr_new;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_addr_o <= '0;
      wb_data_o <= '0;
    end else if (link_en) begin
      wb_addr_o <= link_reg;
      wb_data_o <= link_val;
    end
  end
endmodule

// File: rtl/brk_exec_unit_chk.sv
module brk_exec_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        imm_pfx_valid_i,
  input logic        dslot_pend_i,
  input logic        hw_brk_i,
  input logic [31:0] base_vec_i,
  input logic        redirect_o,
  input logic [31:0] next_pc_o,
  input logic        wb_en_o,
  input logic [4:0]  wb_addr_o,
  input logic        msr_we_o,
  input logic [31:0] msr_o,
  input logic        res_clr_o,
  input logic        trap_o,
  input logic        hw_ack_o
);
  AST_TRAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !redirect_o && !wb_en_o && !msr_we_o && !res_clr_o); // R8
  AST_TRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable(next_pc_o) && $stable(msr_o)); // R8
  AST_NO_R0_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_addr_o != 5'd0); // R4
  AST_RES_CLR_INSN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_clr_o |-> redirect_o && !hw_ack_o); // R5
  AST_HW_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_brk_i && !imm_pfx_valid_i && !dslot_pend_i |=>
      hw_ack_o && next_pc_o == $past(base_vec_i) + 32'h18 && wb_addr_o == 5'd16); // R9
  AST_HW_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_ack_o |-> msr_o[3] && !msr_o[11] && !msr_o[13]); // R9
  AST_HW_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_brk_i && (imm_pfx_valid_i || dslot_pend_i) |=> !hw_ack_o); // R10
endmodule

bind brk_exec_unit brk_exec_unit_chk u_chk (.*);

// File: tb/brk_exec_unit_test.sv
module brk_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic valid, pfx_v, dslot, hw;
  logic [31:0] instr, pc, rb, msr, base;
  logic [15:0] pfx;
  logic redirect, wb_en, msr_we, res_clr, trap, hw_ack;
  logic [31:0] npc, wb_data, msr_out;
  logic [4:0] wb_addr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .pc_i(pc),
    .rb_val_i(rb), .imm_pfx_valid_i(pfx_v), .imm_pfx_i(pfx), .dslot_pend_i(dslot),
    .msr_i(msr), .base_vec_i(base), .hw_brk_i(hw), .redirect_o(redirect),
    .next_pc_o(npc), .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .msr_we_o(msr_we), .msr_o(msr_out), .res_clr_o(res_clr), .trap_o(trap),
    .hw_ack_o(hw_ack)
  );

  function automatic logic [31:0] enc_reg(logic [4:0] rd, logic [4:0] rbi);
    return {6'b100110, rd, 5'b01100, rbi, 11'b0};
  endfunction
  function automatic logic [31:0] enc_imm(logic [4:0] rd, logic [15:0] imm);
    return {6'b101110, rd, 5'b01100, imm};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    valid = 0; instr = '0; pc = '0; rb = '0; pfx_v = 0; pfx = '0;
    dslot = 0; msr = '0; hw = 0;
  endtask

  // drive at negedge, sample one clock later away from the edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_exec(input string req, input logic [31:0] e_pc, input logic e_wb,
                          input logic [4:0] e_ra, input logic [31:0] e_wd,
                          input logic [31:0] e_msr, input logic e_res);
    chk(redirect == 1'b1, req, "redirect", {31'b0, redirect}, 32'd1);
    chk(npc == e_pc, req, "next_pc", npc, e_pc);
    chk(wb_en == e_wb, req, "wb_en", {31'b0, wb_en}, {31'b0, e_wb});
    if (e_wb) begin
      chk(wb_addr == e_ra, req, "wb_addr", {27'b0, wb_addr}, {27'b0, e_ra});
      chk(wb_data == e_wd, req, "wb_data", wb_data, e_wd);
    end
    chk(msr_we && msr_out == e_msr, req, "msr", msr_out, e_msr);
    chk(res_clr == e_res, req, "res_clr", {31'b0, res_clr}, {31'b0, e_res});
    chk(trap == 1'b0, req, "trap", {31'b0, trap}, 32'd0);
  endtask

  task automatic exp_none(input string req);
    chk({redirect, wb_en, msr_we, res_clr, trap, hw_ack} == 6'b0, req, "strobes",
        {26'b0, redirect, wb_en, msr_we, res_clr, trap, hw_ack}, 32'd0);
  endtask

  task automatic t_reset();
    exp_none("R11");
    chk(npc == 0 && msr_out == 0 && wb_data == 0, "R11", "data", npc | msr_out | wb_data, 0);
  endtask

  task automatic t_brk_kernel();
    @(negedge clk); idle(); valid = 1; instr = enc_reg(5'd5, 5'd3);
    rb = 32'h1234_5678; pc = 32'h100; msr = 32'h8000_0001;
    step();
    exp_exec("R2", 32'h1234_5678, 1, 5'd5, 32'h104, 32'h8000_0009, 1); // R4 R5
    @(negedge clk); idle(); valid = 1; instr = enc_reg(5'd0, 5'd3); rb = 32'h40; pc = 32'h200;
    step();
    exp_exec("R4", 32'h40, 0, 5'd0, 0, 32'h8, 1);
  endtask

  task automatic t_decode_reject();
    @(negedge clk); idle(); valid = 1; instr = enc_reg(5'd5, 5'd3) | 32'h1; rb = 32'h999;
    step(); exp_none("R1");
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd2, 16'h40) ^ 32'h0001_0000;
    step(); exp_none("R1");
    @(negedge clk); idle(); valid = 0; instr = enc_imm(5'd2, 16'h40);
    step(); exp_none("R1");
  endtask

  task automatic t_imm_vectors();
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd7, 16'h0040); pc = 32'h300; msr = 32'h2000;
    step(); exp_exec("R6", 32'h40, 1, 5'd7, 32'h304, 32'h2008, 1);
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd0, 16'h0018); msr = 32'h2000;
    step(); exp_exec("R7", 32'h18, 0, 0, 0, 32'h4000, 1); // R6: no BIP
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd0, 16'h0000); msr = 32'h0;
    step(); exp_exec("R6", 32'h0, 0, 0, 0, 32'h8, 1);
  endtask

  task automatic t_imm_widen();
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd1, 16'h8000); pc = 32'h10;
    step(); exp_exec("R3", 32'hFFFF_8000, 1, 5'd1, 32'h14, 32'h8, 1);
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd1, 16'h0010);
    pfx_v = 1; pfx = 16'hABCD; pc = 32'h20;
    step(); exp_exec("R3", 32'hABCD_0010, 1, 5'd1, 32'h24, 32'h8, 1);
  endtask

  task automatic t_user();
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd0, 16'h0008); msr = 32'h2800;
    step(); exp_exec("R8", 32'h8, 0, 0, 0, 32'h5008, 1); // R7
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd3, 16'h0040); msr = 32'h0800;
    step();
    chk(trap == 1, "R8", "trap", {31'b0, trap}, 1);
    chk({redirect, wb_en, msr_we, res_clr} == 0, "R8", "strobes",
        {28'b0, redirect, wb_en, msr_we, res_clr}, 0);
    chk(npc == 32'h8 && msr_out == 32'h5008, "R8", "held pc", npc, 32'h8);
    @(negedge clk); idle();
    step(); chk(trap == 0, "R8", "pulse", {31'b0, trap}, 0);
    @(negedge clk); idle(); valid = 1; instr = enc_reg(5'd3, 5'd1); rb = 32'h77; msr = 32'h0800;
    step();
    chk(trap == 1 && redirect == 0 && npc == 32'h8, "R8", "reg trap", npc, 32'h8);
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd0, 16'h0000); msr = 32'h0800;
    step(); chk(trap == 1 && redirect == 0, "R8", "imm0 user", {31'b0, trap}, 1);
  endtask

  task automatic t_hw();
    @(negedge clk); idle(); valid = 1; instr = enc_reg(5'd5, 5'd1); rb = 32'h55;
    pc = 32'h200; msr = 32'h0800; base = 32'h1000_0000; hw = 1;
    step();
    exp_exec("R9", 32'h1000_0018, 1, 5'd16, 32'h200, 32'h1008, 0); // R10 priority
    chk(hw_ack == 1, "R10", "hw_ack", {31'b0, hw_ack}, 1);
    @(negedge clk); idle(); valid = 1; instr = enc_imm(5'd2, 16'h0040); pc = 32'h400;
    dslot = 1; hw = 1;
    step();
    exp_exec("R10", 32'h40, 1, 5'd2, 32'h404, 32'h8, 1);
    chk(hw_ack == 0, "R10", "blocked", {31'b0, hw_ack}, 0);
  endtask

  initial begin
    idle(); base = 32'h1000_0000;
    #(3*CLK_PERIOD + 2); rst_n = 1;
    t_reset();
    t_brk_kernel();
    t_decode_reject();
    t_imm_vectors();
    t_imm_widen();
    t_user();
    t_hw();
    @(negedge clk); idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20000*CLK_PERIOD);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule